// File: doc/BRIEF.md
# Reset and start-up delay controller

This block gathers every reset and wake-up cause of a small microcontroller core into one internal system reset. Power-on, the active-low external reset pin, a watchdog expiry pulse, a USB bus reset pulse and a wake-up request taken while the core sits in its HALT state all lead to the same result. The core is held in reset, and a fixed oscillator settling time of 2^DLY_W clocks (1024 by default) must pass before it is let go. During that reset the core returns its program counter to zero, disables interrupts, clears the prescaler and watchdog, stops the timer and turns every I/O port into an input. The block only supplies the reset that triggers those actions.

Alongside the reset, the block drives a cold/warm indication. The core uses it to choose whether general-purpose registers are wiped (cold) or kept (warm). Control registers return to their defaults on either kind. The block also keeps two status bits, a time-out flag and a power-down flag. Each event sets, clears or keeps them according to which event occurred and whether the core was halted at that moment. The core's own halt indication is sampled on the same clock edge that takes the event.

The pin and the wake-up request are asynchronous and pass through synchronisers of SYNC_STAGES flops (two by default). The watchdog and USB pulses are synchronous, one clock wide. A new event that arrives during a running delay restarts the count and applies its own flag update.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While por_n is low, sys_rst=1, cold_rst=1, to_flag=0 and pd_flag=0. After por_n rises, sys_rst stays 1 through the 1023rd rising clock edge and is 0 after the 1024th.
- R2: A one-cycle wdt_to or usb_rst pulse seen on edge E drives sys_rst to 1 after E. sys_rst stays 1 through edge E+1023 and is 0 after edge E+1024.
- R3: ext_rst_n passes a two-flop synchroniser. sys_rst is 1 after the 3rd edge following the pin falling and stays 1 for as long as the pin is low. After the pin rises, sys_rst stays 1 through the 1025th edge and is 0 after the 1026th, which is 1024 counting cycles once the synchronised level is high.
- R4: A rising wake_req, after its two-flop synchroniser, starts a delay when halted=1 and no delay is running. sys_rst is 1 after the 3rd edge, stays 1 through the 1026th edge and is 0 after the 1027th. The flags keep their values.
- R5: A rising wake_req while halted=0 is ignored: sys_rst stays 0, and cold_rst, to_flag and pd_flag are unchanged.
- R6: cold_rst is 1 after power-on and becomes 0 after any pin, watchdog, USB or wake event.
- R7: Watchdog event: when not halted, to_flag=1 and pd_flag is unchanged. When halted, to_flag=1 and pd_flag=1.
- R8: Pin event: when not halted, both flags are unchanged. When halted, to_flag=0 and pd_flag=0.
- R9: USB event: when not halted, both flags are unchanged. When halted, to_flag=0 and pd_flag=1.
- R10: An event during a running delay restarts the count, so R2 timing is measured from the newest event, and the newest event's flag update is applied.
- R11: When events coincide on one edge, only the highest-priority one updates the flags. The order is pin, then watchdog, then USB, then wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on indication, low while power is not good (asynchronous) |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_to | input | 1 | Watchdog expiry, one-cycle synchronous pulse |
| usb_rst | input | 1 | USB bus reset, one-cycle synchronous pulse |
| halted | input | 1 | Core is in its HALT state |
| wake_req | input | 1 | Wake-up request, asynchronous, rising edge used |
| sys_rst | output | 1 | Internal system reset, active high |
| cold_rst | output | 1 | 1 when the latest reset was a power-on (cold) reset |
| to_flag | output | 1 | Time-out status bit |
| pd_flag | output | 1 | Power-down status bit |

## Verification
Each result has a fixed latency. Flag and cold/warm updates, and the rising edge of sys_rst, appear one edge after a synchronous pulse and three edges after a pin or wake change, because of the two synchroniser flops. sys_rst falls on the 1024th edge after a pulse or after power-on release, on the 1026th edge after the pin rises, and on the 1027th edge after a wake-up request rises. Every check steps an exact number of rising edges and samples 1 ns after the last one. Each release is confirmed twice: sys_rst must still be high one edge before its due time and low exactly at it, so a delay that is off by one cycle in either direction is caught.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   // Winning event on one clock edge; order of the case in the arbiter is the priority
   typedef enum logic [2:0] {
      EV_NONE = 3'd0,
      EV_PIN  = 3'd1,
      EV_WDT  = 3'd2,
      EV_USB  = 3'd3,
      EV_WAKE = 3'd4
   } rst_evt_e;

   typedef struct packed {
      logic to;
      logic pd;
   } stat_t;

   // Status-bit update for one event, given whether the core was halted
   function automatic stat_t next_stat(rst_evt_e ev, logic hlt, stat_t cur);
      stat_t n;
      n = cur;
      case (ev)
         EV_WDT: begin
            n.to = 1'b1;
            if (hlt) n.pd = 1'b1;
         end
         EV_PIN: begin
            if (hlt) begin
               n.to = 1'b0;
               n.pd = 1'b0;
            end
         end
         EV_USB: begin
            if (hlt) begin
               n.to = 1'b0;
               n.pd = 1'b1;
            end
         end
         default: n = cur;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rst_evt_arb.sv
module rst_evt_arb
   import rst_seq_pkg::*;
(
   input  logic     pin_fall,
   input  logic     wdt_evt,
   input  logic     usb_evt,
   input  logic     wake_evt,
   output rst_evt_e ev
);

   always_comb begin
      if (pin_fall)      ev = EV_PIN;
      else if (wdt_evt)  ev = EV_WDT;
      else if (usb_evt)  ev = EV_USB;
      else if (wake_evt) ev = EV_WAKE;
      else               ev = EV_NONE;
   end

endmodule

// File: rtl/rst_stat_reg.sv
module rst_stat_reg
   import rst_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  rst_evt_e ev,
   input  logic     hlt,
   output stat_t    stat,
   output logic     cold
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         cold <= 1'b1;
      end else if (ev != EV_NONE) begin
         stat <= next_stat(ev, hlt, stat);
         cold <= 1'b0;
      end
   end

endmodule

// File: rtl/rst_delay_cnt.sv
module rst_delay_cnt #(
   parameter int W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic hold,
   output logic busy
);

   logic [W-1:0] cnt;
   logic [W:0]   nxt;

   always_comb nxt = {1'b0, cnt} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (start || hold) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         cnt <= nxt[W-1:0];
         if (nxt[W]) busy <= 1'b0;
      end
   end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
   import rst_seq_pkg::*;
#(
   parameter int DLY_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic ext_rst_n,
   input  logic wdt_to,
   input  logic usb_rst,
   input  logic halted,
   input  logic wake_req,
   output logic sys_rst,
   output logic cold_rst,
   output logic to_flag,
   output logic pd_flag
);

   if (DLY_W < 2 || DLY_W > 24) begin : g_bad_dly
      $error("rst_seq_ctrl: DLY_W out of range 2..24");
   end

   logic     pin_s, pin_low, pin_low_q, pin_fall;
   logic     wake_s, wake_q, wake_ok;
   logic     busy;
   rst_evt_e ev;
   stat_t    stat;

   rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk(clk), .rst_n(por_n), .d(ext_rst_n), .q(pin_s)
   );

   rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_sync (
      .clk(clk), .rst_n(por_n), .d(wake_req), .q(wake_s)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pin_low_q <= 1'b0;
         wake_q    <= 1'b0;
      end else begin
         pin_low_q <= pin_low;
         wake_q    <= wake_s;
      end
   end

   assign pin_low  = ~pin_s;
   assign pin_fall = pin_low & ~pin_low_q;
   assign wake_ok  = wake_s & ~wake_q & halted & ~busy;

   rst_evt_arb u_arb (
      .pin_fall(pin_fall), .wdt_evt(wdt_to), .usb_evt(usb_rst),
      .wake_evt(wake_ok), .ev(ev)
   );

   rst_stat_reg u_stat (
      .clk(clk), .rst_n(por_n), .ev(ev), .hlt(halted),
      .stat(stat), .cold(cold_rst)
   );

   rst_delay_cnt #(.W(DLY_W)) u_dly (
      .clk(clk), .rst_n(por_n), .start(ev != EV_NONE), .hold(pin_low),
      .busy(busy)
   );

   assign sys_rst = busy;
   assign to_flag = stat.to;
   assign pd_flag = stat.pd;

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
   input logic clk,
   input logic por_n,
   input logic wdt_to,
   input logic usb_rst,
   input logic halted,
   input logic pin_low,
   input logic pin_fall,
   input logic sys_rst,
   input logic cold_rst,
   input logic to_flag,
   input logic pd_flag
);

   // R7
   wdt_run_flags_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wdt_to && !halted && !pin_fall) |=> (to_flag && sys_rst && $stable(pd_flag)));

   // R7
   wdt_halt_flags_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wdt_to && halted && !pin_fall) |=> (to_flag && pd_flag));

   // R9
   usb_halt_flags_chk: assert property (@(posedge clk) disable iff (!por_n)
      (usb_rst && halted && !wdt_to && !pin_fall) |=> (!to_flag && pd_flag));

   // R3
   pin_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      pin_low |=> sys_rst);

   // R3
   no_release_in_pin_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(sys_rst) |-> !$past(pin_low));

   // R6
   warm_mark_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wdt_to || usb_rst || pin_fall) |=> !cold_rst);

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (.*);

// File: tb/rst_seq_ctrl_test.sv
`timescale 1ns/1ps
module rst_seq_ctrl_test;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic ext_rst_n = 1'b1;
   logic wdt_to = 1'b0;
   logic usb_rst = 1'b0;
   logic halted = 1'b0;
   logic wake_req = 1'b0;
   logic sys_rst, cold_rst, to_flag, pd_flag;

   int total = 0;
   int bad = 0;
   logic e_to, e_pd, e_cold;

   rst_seq_ctrl uut (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_to(wdt_to),
      .usb_rst(usb_rst), .halted(halted), .wake_req(wake_req),
      .sys_rst(sys_rst), .cold_rst(cold_rst), .to_flag(to_flag), .pd_flag(pd_flag)
   );

   always #4 clk = ~clk;

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic chk_state(input string req);
      chk(req, "to_flag", to_flag, e_to);
      chk(req, "pd_flag", pd_flag, e_pd);
      chk(req, "cold_rst", cold_rst, e_cold);
   endtask

   // expected flag model written from the requirement text
   task automatic model(input string kind, input logic h);
      if (kind == "wdt") begin
         e_to = 1'b1;
         if (h) e_pd = 1'b1;
      end else if (kind == "pin") begin
         if (h) begin e_to = 1'b0; e_pd = 1'b0; end
      end else if (kind == "usb") begin
         if (h) begin e_to = 1'b0; e_pd = 1'b1; end
      end
      e_cold = 1'b0;
   endtask

   task automatic expect_release(input string req, input int high_edges);
      step(high_edges);
      chk(req, "sys_rst before release", sys_rst, 1'b1);
      step(1);
      chk(req, "sys_rst at release", sys_rst, 1'b0);
   endtask

   task automatic t_power_on();
      step(3);
      chk("R1", "sys_rst in por", sys_rst, 1'b1);
      e_to = 1'b0; e_pd = 1'b0; e_cold = 1'b1;
      chk_state("R1");
      por_n = 1'b1;
      expect_release("R1", 1023);
   endtask

   task automatic t_wake_ignored();
      halted = 1'b0;
      wake_req = 1'b1;
      step(6);
      chk("R5", "sys_rst", sys_rst, 1'b0);
      chk_state("R5");
      wake_req = 1'b0;
      step(4);
   endtask

   task automatic t_wake();
      halted = 1'b1;
      wake_req = 1'b1;
      step(3);
      halted = 1'b0;
      wake_req = 1'b0;
      chk("R4", "sys_rst after wake", sys_rst, 1'b1);
      e_cold = 1'b0;
      chk_state("R4");
      expect_release("R4", 1023);
   endtask

   task automatic t_pulse(input string req, input logic w, input logic u, input logic h);
      halted = h;
      wdt_to = w;
      usb_rst = u;
      step(1);
      wdt_to = 1'b0;
      usb_rst = 1'b0;
      halted = 1'b0;
      chk(req, "sys_rst after pulse", sys_rst, 1'b1);
      if (w) model("wdt", h);
      else   model("usb", h);
      chk_state(req);
      expect_release("R2", 1023);
   endtask

   task automatic t_pin(input string req, input logic h, input int hold);
      halted = h;
      ext_rst_n = 1'b0;
      step(3);
      halted = 1'b0;
      chk("R3", "sys_rst after pin fall", sys_rst, 1'b1);
      model("pin", h);
      chk_state(req);
      step(hold);
      chk("R3", "sys_rst while pin low", sys_rst, 1'b1);
      ext_rst_n = 1'b1;
      expect_release("R3", 1025);
   endtask

   task automatic t_restart();
      halted = 1'b1;
      usb_rst = 1'b1;
      step(1);
      usb_rst = 1'b0;
      halted = 1'b0;
      model("usb", 1'b1);
      step(500);
      chk("R10", "sys_rst mid delay", sys_rst, 1'b1);
      wdt_to = 1'b1;
      step(1);
      wdt_to = 1'b0;
      model("wdt", 1'b0);
      chk_state("R10");
      expect_release("R10", 1023);
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2;
      t_power_on();
      t_wake_ignored();
      t_wake();
      t_pulse("R7", 1'b1, 1'b0, 1'b0);
      t_pulse("R9", 1'b0, 1'b1, 1'b1);
      t_pulse("R9", 1'b0, 1'b1, 1'b0);
      t_pulse("R7", 1'b1, 1'b0, 1'b1);
      t_pin("R8", 1'b0, 10);
      t_pin("R8", 1'b1, 2000);
      // R11: watchdog outranks USB on the same edge while halted
      t_pulse("R11", 1'b1, 1'b1, 1'b1);
      t_restart();
      // R6: cold_rst returns after a fresh power-on
      por_n = 1'b0;
      #3;
      chk("R6", "cold_rst after por", cold_rst, 1'b1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule